// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is the data side of a simple processor in which every transfer between registers crosses one shared internal bus. It holds a general register file, a program counter, an instruction register, a memory address register, a memory data register, an ALU operand latch and an ALU result latch. An external sequencer drives it every clock with a set of gating strobes. Each strobe either places one source on the bus or loads one destination from it. The sequencer also supplies the ALU function, the carry-in, the memory read and write commands and a wait-for-completion request.

The memory data register has two sides. Its bus side connects to the internal bus. Its memory side connects to the external data lines. Memory accesses are started by a command strobe. The command stays pending on the memory port until the memory returns its completion acknowledge. A wait-for-completion step that has not been acknowledged freezes every register in the datapath. While that wait lasts, the block raises a stall output so that the sequencer can keep its step number.

Top module: `sbus_datapath`

## Requirements
- R1: At most one source drives the internal bus in a cycle. `bus_mon` shows the source whose out-strobe is active: a register, the PC, the bus side of the MDR, Z, or the sign-extended low 16 bits of IR (`off_oe`). With no out-strobe active, it reads zero.
- R2: A register copy completes in one step. When `gpr_oe`/`gpr_oidx` and `gpr_ie`/`gpr_iidx` are active in the same cycle, the destination holds the source value after that clock edge.
- R3: The ALU operand A is Y, or the constant 4 when `const4_sel` is 1. Operand B is the bus. The functions are 0 = A+B+cin, 1 = A-B, 2 = A AND B and 3 = A XOR B. The result enters only Z, and only when `z_ie` is 1. Otherwise Z keeps its value.
- R4: A three-operand operation takes three steps: first operand into Y, second operand on the bus with Z loading, then Z into the destination register.
- R5: A PC increment puts PC on the bus with the constant 4 selected, ADD and Z loading, then moves Z into PC. This advances PC by 4.
- R6: When `rd_cmd` is set in a step that is not stalled, MAR loads from the bus. `mem_rd` is 1 from the next cycle until the cycle after `mfc`. With `mdr_mem_ie`, MDR captures `mem_rdata` at the edge where the wait is satisfied.
- R7: When `wr_cmd` is set in a step that is not stalled, `mem_wr` is 1 from the next cycle until the cycle after `mfc`. `mem_wdata` shows MDR while `mdr_mem_oe` is 1 and zero otherwise.
- R8: `stall` equals `wait_mfc` AND NOT `mfc`. While it is 1, no register (file, PC, IR, MAR, MDR, Y, Z) changes at the clock edge.
- R9: Synchronous active-high reset clears all registers, `mem_rd` and `mem_wr`.
- R10: With `off_oe` on the bus, PC plus the sign-extended IR offset can be formed in Z and loaded into PC. This gives a relative jump, including a backward one.
- R11: When `mdr_ie` and `mdr_mem_ie` are both 1, MDR loads from the memory data lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| gpr_oe | input | 1 | Register file drives bus |
| gpr_oidx | input | RIDX | Index of register driving bus |
| gpr_ie | input | 1 | Register file loads from bus |
| gpr_iidx | input | RIDX | Index of register loaded |
| pc_oe | input | 1 | PC drives bus |
| pc_ie | input | 1 | PC loads from bus |
| ir_ie | input | 1 | IR loads from bus |
| off_oe | input | 1 | Sign-extended IR offset drives bus |
| mar_ie | input | 1 | MAR loads from bus |
| mdr_oe | input | 1 | MDR drives bus |
| mdr_ie | input | 1 | MDR loads from bus |
| mdr_mem_ie | input | 1 | MDR loads from memory data lines |
| mdr_mem_oe | input | 1 | MDR drives memory data lines |
| y_ie | input | 1 | Y loads from bus |
| z_oe | input | 1 | Z drives bus |
| z_ie | input | 1 | Z loads ALU result |
| const4_sel | input | 1 | ALU operand A is constant 4 |
| alu_fn | input | 2 | ALU function code |
| alu_cin | input | 1 | ALU carry-in for ADD |
| rd_cmd | input | 1 | Start memory read |
| wr_cmd | input | 1 | Start memory write |
| wait_mfc | input | 1 | Hold step until memory completion |
| mfc | input | 1 | Memory function complete |
| mem_rdata | input | DW | Memory read data |
| mem_addr | output | DW | Memory address (MAR) |
| mem_wdata | output | DW | Memory write data |
| mem_rd | output | 1 | Read pending |
| mem_wr | output | 1 | Write pending |
| stall | output | 1 | Unsatisfied completion wait |
| bus_mon | output | DW | Internal bus value |
| pc_q | output | DW | Program counter |
| ir_q | output | DW | Instruction register |

## Verification
A register that is loaded wrongly, or that changes during a stall, stays hidden until a later step places it on the bus. The bench therefore reads every result back through `bus_mon` one step after the load. Faults in the ALU, the operand multiplexer or Z show up three steps into an operation, at the read-back of the destination. A pending flag that clears early or late shows up on `mem_rd`/`mem_wr` in the cycle after the command or after `mfc`. A fault in the stall gating shows up on `pc_q` and `mem_addr` at the first stalled edge.

// File: rtl/sbus_pkg.sv
package sbus_pkg;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_XOR = 2'd3
    } alu_fn_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_GPR,
        SRC_PC,
        SRC_MDR,
        SRC_Z,
        SRC_OFF
    } bus_src_e;

    typedef struct packed {
        logic pc;
        logic ir;
        logic y;
        logic z;
        logic gpr;
    } load_s;

    localparam int unsigned PC_STEP = 4;

    function automatic bus_src_e pick_src(input logic gpr, input logic pc,
                                          input logic mdr, input logic z,
                                          input logic off);
        if (gpr)      return SRC_GPR;
        else if (pc)  return SRC_PC;
        else if (mdr) return SRC_MDR;
        else if (z)   return SRC_Z;
        else if (off) return SRC_OFF;
        return SRC_NONE;
    endfunction

endpackage

// File: rtl/sbus_regfile.sv
module sbus_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 8,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [RIDX-1:0] widx,
    input  logic [DW-1:0]   wdata,
    input  logic [RIDX-1:0] ridx,
    output logic [DW-1:0]   rdata
);
    logic [DW-1:0] cell_q [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_cell
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (we && widx == RIDX'(g))
                q <= wdata;
        end
        assign cell_q[g] = q;
    end

    assign rdata = cell_q[ridx];
endmodule

// File: rtl/sbus_alu.sv
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    input  alu_fn_e       fn,
    output logic [DW-1:0] res
);
    always_comb begin
        unique case (fn)
            ALU_ADD: res = a + b + {{(DW-1){1'b0}}, cin};
            ALU_SUB: res = a - b;
            ALU_AND: res = a & b;
            ALU_XOR: res = a ^ b;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/sbus_memif.sv
module sbus_memif #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic [DW-1:0] bus,
    input  logic          mar_ld,
    input  logic          mdr_ld_bus,
    input  logic          mdr_ld_mem,
    input  logic          mdr_drive,
    input  logic          rd_req,
    input  logic          wr_req,
    input  logic          mfc,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mar_q,
    output logic [DW-1:0] mdr_q,
    output logic [DW-1:0] mem_wdata,
    output logic          rd_pend,
    output logic          wr_pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q <= '0;
            mdr_q <= '0;
        end else if (!hold) begin
            if (mar_ld)
                mar_q <= bus;
            if (mdr_ld_mem)
                mdr_q <= mem_rdata;
            else if (mdr_ld_bus)
                mdr_q <= bus;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend <= 1'b0;
            wr_pend <= 1'b0;
        end else begin
            if (rd_req && !hold)
                rd_pend <= 1'b1;
            else if (mfc)
                rd_pend <= 1'b0;
            if (wr_req && !hold)
                wr_pend <= 1'b1;
            else if (mfc)
                wr_pend <= 1'b0;
        end
    end

    assign mem_wdata = mdr_drive ? mdr_q : '0;
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NREG  = 8,
    parameter int OFF_W = 16,
    localparam int RIDX = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            gpr_oe,
    input  logic [RIDX-1:0] gpr_oidx,
    input  logic            gpr_ie,
    input  logic [RIDX-1:0] gpr_iidx,
    input  logic            pc_oe,
    input  logic            pc_ie,
    input  logic            ir_ie,
    input  logic            off_oe,
    input  logic            mar_ie,
    input  logic            mdr_oe,
    input  logic            mdr_ie,
    input  logic            mdr_mem_ie,
    input  logic            mdr_mem_oe,
    input  logic            y_ie,
    input  logic            z_oe,
    input  logic            z_ie,
    input  logic            const4_sel,
    input  logic [1:0]      alu_fn,
    input  logic            alu_cin,
    input  logic            rd_cmd,
    input  logic            wr_cmd,
    input  logic            wait_mfc,
    input  logic            mfc,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic            stall,
    output logic [DW-1:0]   bus_mon,
    output logic [DW-1:0]   pc_q,
    output logic [DW-1:0]   ir_q
);
    localparam int EXT_W = DW - OFF_W;

    logic          hold;
    load_s         ld;
    bus_src_e      src;
    logic [DW-1:0] bus;
    logic [DW-1:0] gpr_rd;
    logic [DW-1:0] mdr_q;
    logic [DW-1:0] y_q;
    logic [DW-1:0] z_q;
    logic [DW-1:0] alu_a;
    logic [DW-1:0] alu_res;
    logic [DW-1:0] off_ext;

    assign hold  = wait_mfc && !mfc;
    assign stall = hold;

    always_comb begin
        ld.pc  = pc_ie  && !hold;
        ld.ir  = ir_ie  && !hold;
        ld.y   = y_ie   && !hold;
        ld.z   = z_ie   && !hold;
        ld.gpr = gpr_ie && !hold;
    end

    assign off_ext = {{EXT_W{ir_q[OFF_W-1]}}, ir_q[OFF_W-1:0]};
    assign src     = pick_src(gpr_oe, pc_oe, mdr_oe, z_oe, off_oe);

    always_comb begin
        unique case (src)
            SRC_GPR: bus = gpr_rd;
            SRC_PC:  bus = pc_q;
            SRC_MDR: bus = mdr_q;
            SRC_Z:   bus = z_q;
            SRC_OFF: bus = off_ext;
            default: bus = '0;
        endcase
    end
    assign bus_mon = bus;

    sbus_regfile #(.DW(DW), .NREG(NREG)) i_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (ld.gpr),
        .widx  (gpr_iidx),
        .wdata (bus),
        .ridx  (gpr_oidx),
        .rdata (gpr_rd)
    );

    assign alu_a = const4_sel ? DW'(PC_STEP) : y_q;

    sbus_alu #(.DW(DW)) i_alu (
        .a   (alu_a),
        .b   (bus),
        .cin (alu_cin),
        .fn  (alu_fn_e'(alu_fn)),
        .res (alu_res)
    );

    sbus_memif #(.DW(DW)) i_mem (
        .clk        (clk),
        .rst        (rst),
        .hold       (hold),
        .bus        (bus),
        .mar_ld     (mar_ie),
        .mdr_ld_bus (mdr_ie),
        .mdr_ld_mem (mdr_mem_ie),
        .mdr_drive  (mdr_mem_oe),
        .rd_req     (rd_cmd),
        .wr_req     (wr_cmd),
        .mfc        (mfc),
        .mem_rdata  (mem_rdata),
        .mar_q      (mem_addr),
        .mdr_q      (mdr_q),
        .mem_wdata  (mem_wdata),
        .rd_pend    (mem_rd),
        .wr_pend    (mem_wr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            ir_q <= '0;
            y_q  <= '0;
            z_q  <= '0;
        end else begin
            if (ld.pc) pc_q <= bus;
            if (ld.ir) ir_q <= bus;
            if (ld.y)  y_q  <= bus;
            if (ld.z)  z_q  <= alu_res;
        end
    end
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          gpr_oe,
    input logic          pc_oe,
    input logic          mdr_oe,
    input logic          z_oe,
    input logic          off_oe,
    input logic          rd_cmd,
    input logic          wr_cmd,
    input logic          mfc,
    input logic          stall,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [DW-1:0] mem_addr,
    input logic [DW-1:0] pc_q,
    input logic [DW-1:0] ir_q
);
    assert_one_driver_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({gpr_oe, pc_oe, mdr_oe, z_oe, off_oe}));

    assert_stall_freeze_R8: assert property (@(posedge clk) disable iff (rst)
        stall |=> (pc_q == $past(pc_q) && ir_q == $past(ir_q)
                   && mem_addr == $past(mem_addr)));

    assert_rd_start_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rd) |-> $past(rd_cmd));

    assert_rd_keep_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && !mfc) |=> mem_rd);

    assert_wr_keep_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && !mfc) |=> mem_wr);

    assert_done_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (mfc && !rd_cmd && !wr_cmd) |=> (!mem_rd && !mem_wr));

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && !mem_rd && !mem_wr));
endmodule

bind sbus_datapath sbus_datapath_chk #(.DW(DW)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .gpr_oe   (gpr_oe),
    .pc_oe    (pc_oe),
    .mdr_oe   (mdr_oe),
    .z_oe     (z_oe),
    .off_oe   (off_oe),
    .rd_cmd   (rd_cmd),
    .wr_cmd   (wr_cmd),
    .mfc      (mfc),
    .stall    (stall),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .pc_q     (pc_q),
    .ir_q     (ir_q)
);

// File: tb/test_sbus_datapath.sv
`timescale 1ns/1ps
module test_sbus_datapath;
    localparam int DW = 32;
    localparam int RIDX = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gpr_oe, gpr_ie, pc_oe, pc_ie, ir_ie, off_oe, mar_ie;
    logic mdr_oe, mdr_ie, mdr_mem_ie, mdr_mem_oe, y_ie, z_oe, z_ie;
    logic const4_sel, alu_cin, rd_cmd, wr_cmd, wait_mfc, mfc;
    logic [RIDX-1:0] gpr_oidx, gpr_iidx;
    logic [1:0] alu_fn;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] mem_addr, mem_wdata, bus_mon, pc_q, ir_q;
    logic mem_rd, mem_wr, stall;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sbus_datapath i_sbus_datapath (
        .clk(clk), .rst(rst), .gpr_oe(gpr_oe), .gpr_oidx(gpr_oidx),
        .gpr_ie(gpr_ie), .gpr_iidx(gpr_iidx), .pc_oe(pc_oe), .pc_ie(pc_ie),
        .ir_ie(ir_ie), .off_oe(off_oe), .mar_ie(mar_ie), .mdr_oe(mdr_oe),
        .mdr_ie(mdr_ie), .mdr_mem_ie(mdr_mem_ie), .mdr_mem_oe(mdr_mem_oe),
        .y_ie(y_ie), .z_oe(z_oe), .z_ie(z_ie), .const4_sel(const4_sel),
        .alu_fn(alu_fn), .alu_cin(alu_cin), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
        .wait_mfc(wait_mfc), .mfc(mfc), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .stall(stall), .bus_mon(bus_mon), .pc_q(pc_q),
        .ir_q(ir_q)
    );

    function automatic logic [DW-1:0] alu_model(input logic [DW-1:0] a,
            input logic [DW-1:0] b, input logic [1:0] fn, input logic cin);
        case (fn)
            2'd0: return a + b + DW'(cin);
            2'd1: return a - b;
            2'd2: return a & b;
            default: return a ^ b;
        endcase
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clr();
        {gpr_oe, gpr_ie, pc_oe, pc_ie, ir_ie, off_oe, mar_ie} = '0;
        {mdr_oe, mdr_ie, mdr_mem_ie, mdr_mem_oe, y_ie, z_oe, z_ie} = '0;
        {const4_sel, alu_cin, rd_cmd, wr_cmd, wait_mfc, mfc} = '0;
        gpr_oidx = '0; gpr_iidx = '0; alu_fn = '0; mem_rdata = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_r(input int k, input logic [DW-1:0] v);
        clr(); mdr_mem_ie = 1; mem_rdata = v; tick();
        clr(); mdr_oe = 1; gpr_ie = 1; gpr_iidx = RIDX'(k); tick();
        clr();
    endtask

    task automatic read_r(input int k, output logic [DW-1:0] v);
        clr(); gpr_oe = 1; gpr_oidx = RIDX'(k); #1;
        v = bus_mon; clr();
    endtask

    task automatic read_z(output logic [DW-1:0] v);
        clr(); z_oe = 1; #1; v = bus_mon; clr();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v, a, b, e, rv;
        void'($urandom(32'd4711));
        clr();
        repeat (3) @(posedge clk);
        #1; rst = 0;

        // R9 reset state; R1 idle bus reads zero
        chk("R9 pc", pc_q, '0);
        chk("R9 ir", ir_q, '0);
        chk("R9 rd/wr", {30'd0, mem_rd, mem_wr}, '0);
        chk("R1 idle bus", bus_mon, '0);
        for (int k = 0; k < 8; k++) begin
            read_r(k, v); chk("R9 gpr", v, '0);
        end

        // R1 each source on the bus
        load_r(5, 32'hCAFE_0005);
        read_r(5, v); chk("R1 gpr source", v, 32'hCAFE_0005);

        // R2 one-step copy
        clr(); gpr_oe = 1; gpr_oidx = 3'd5; gpr_ie = 1; gpr_iidx = 3'd2; tick();
        read_r(2, v); chk("R2 copy dst", v, 32'hCAFE_0005);
        read_r(5, v); chk("R2 copy src kept", v, 32'hCAFE_0005);

        // R5 PC increment with instruction fetch, R6 read, R8 stall
        clr(); pc_oe = 1; mar_ie = 1; rd_cmd = 1; const4_sel = 1; z_ie = 1; tick();
        chk("R6 rd pending", {31'd0, mem_rd}, 1);
        chk("R6 addr", mem_addr, 32'd0);
        clr(); z_oe = 1; pc_ie = 1; mdr_mem_ie = 1; wait_mfc = 1;
        mem_rdata = 32'h1234_FFF0; #1;
        chk("R8 stall high", {31'd0, stall}, 1);
        chk("R1 z source", bus_mon, 32'd4);
        tick(); tick();
        chk("R8 pc held", pc_q, 32'd0);
        chk("R6 rd held", {31'd0, mem_rd}, 1);
        mfc = 1; #1;
        chk("R8 stall low on mfc", {31'd0, stall}, 0);
        tick();
        chk("R5 pc plus 4", pc_q, 32'd4);
        chk("R6 rd cleared", {31'd0, mem_rd}, 0);
        clr(); mdr_oe = 1; ir_ie = 1; tick();
        chk("R6 ir from memory", ir_q, 32'h1234_FFF0);

        // R10 relative backward jump: pc(4) + sext(0xFFF0) = 4 - 16
        clr(); pc_oe = 1; y_ie = 1; tick();
        clr(); off_oe = 1; #1;
        chk("R1 offset source", bus_mon, 32'hFFFF_FFF0);
        z_ie = 1; tick();
        clr(); z_oe = 1; pc_ie = 1; tick();
        chk("R10 jump target", pc_q, 32'hFFFF_FFF4);

        // R7 write sequence with stall
        load_r(1, 32'h0000_0100);
        load_r(6, 32'hDEAD_BEEF);
        clr(); gpr_oe = 1; gpr_oidx = 3'd1; mar_ie = 1; tick();
        clr(); gpr_oe = 1; gpr_oidx = 3'd6; mdr_ie = 1; wr_cmd = 1; tick();
        chk("R7 wr pending", {31'd0, mem_wr}, 1);
        chk("R7 addr", mem_addr, 32'h100);
        chk("R7 wdata idle zero", mem_wdata, '0);
        clr(); mdr_mem_oe = 1; wait_mfc = 1; #1;
        chk("R7 wdata", mem_wdata, 32'hDEAD_BEEF);
        tick();
        chk("R7 wr held", {31'd0, mem_wr}, 1);
        mfc = 1; tick();
        chk("R7 wr cleared", {31'd0, mem_wr}, 0);

        // R8 stall freezes register file and Z
        load_r(4, 32'h0000_0011);
        clr(); gpr_oe = 1; gpr_oidx = 3'd6; gpr_ie = 1; gpr_iidx = 3'd4;
        z_ie = 1; wait_mfc = 1; tick(); tick();
        read_r(4, v); chk("R8 gpr frozen", v, 32'h0000_0011);

        // R11 memory side wins over bus side
        clr(); gpr_oe = 1; gpr_oidx = 3'd6; mdr_ie = 1; mdr_mem_ie = 1;
        mem_rdata = 32'h5555_AAAA; tick();
        clr(); mdr_oe = 1; #1; chk("R11 mdr from memory", bus_mon, 32'h5555_AAAA);
        clr();

        // R3 const4 operand and Z kept without z_ie
        load_r(0, 32'h0000_0010);
        clr(); gpr_oe = 1; gpr_oidx = 3'd0; const4_sel = 1; alu_fn = 2'd1; z_ie = 1; tick();
        read_z(v); chk("R3 const4 minus bus", v, 32'hFFFF_FFF4);
        clr(); gpr_oe = 1; gpr_oidx = 3'd0; const4_sel = 1; tick();
        read_z(v); chk("R3 z held without z_ie", v, 32'hFFFF_FFF4);

        // R4 / R3 random three-step operations
        for (int n = 0; n < 40; n++) begin
            int sa, sb, dst;
            logic [1:0] fn;
            logic cin;
            a = $urandom; b = $urandom;
            fn = 2'($urandom_range(0, 3)); cin = 1'($urandom_range(0, 1));
            sa = $urandom_range(0, 7);
            sb = (sa + 1 + $urandom_range(0, 6)) % 8;
            dst = $urandom_range(0, 7);
            load_r(sa, a); load_r(sb, b);
            clr(); gpr_oe = 1; gpr_oidx = RIDX'(sa); y_ie = 1; tick();
            clr(); gpr_oe = 1; gpr_oidx = RIDX'(sb); alu_fn = fn; alu_cin = cin;
            z_ie = 1; tick();
            clr(); z_oe = 1; gpr_ie = 1; gpr_iidx = RIDX'(dst); tick();
            e = alu_model(a, b, fn, cin);
            read_r(dst, rv); chk("R4 R3 three-step op", rv, e);
        end

        // R9 reset mid-run clears
        clr(); rd_cmd = 1; tick();
        rst = 1; tick(); rst = 0;
        chk("R9 reset clears rd", {31'd0, mem_rd}, 0);
        chk("R9 reset clears pc", pc_q, '0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule